// File: doc/BRIEF.md
# Dual-Strobe Master Link Serializer

This block is the host-side engine of a half-duplex serial link to a display module. A host drives a parallel port made of 18 data bits, 6 control bits, a read/write flag and a select bit, and it marks each transfer with one of two strobes. In SPI pass-through mode it uses a serial clock carried on control bit 5 instead. The block brings the selected strobe into its own clock domain, detects the edge that starts a transaction, captures the port and shifts a frame out on a link clock/data pair. One frame bit is sent for each internal clock cycle in which the link clock output is high.

A write sends the whole word. A read sends only a short control frame. The block then releases the link and waits for the far end to send back a data frame. It presents the returned 18 bits to the host until the host closes the read with the opposite strobe edge. Between transactions the link lines stay low so that the link draws as little power as possible.

Top module: `dsl_master`

## Requirements
- R1: The active strobe is chosen as follows. With `par_mode`=1, `host_sel`=0 selects `strb0` and `host_sel`=1 selects `strb1`. With `par_mode`=0, `host_sel`=1 selects `strb1` and `host_sel`=0 selects `host_ctl[5]` (the SPI clock). Edges on a strobe that is not selected start nothing.
- R2: A rising edge of the active strobe with `host_rw`=0 sends a 27-bit frame, most significant bit first: a start bit of 1, then `host_sel`, `host_rw`, `host_ctl[5:0]` and `host_dat[17:0]`.
- R3: A falling edge of the active strobe with `host_rw`=1 (and not in SPI channel-0 mode) sends a 9-bit frame: start bit 1, `host_sel`, `host_rw` and `host_ctl[5:0]`. `host_dat` is not sent.
- R4: After the last bit of a read frame, `lnk_oe` goes low in the next cycle and stays low until a return frame has arrived. The return frame is a start bit of 1, then 18 data bits and then 6 control bits, MSB first, each valid in a cycle with `lnk_rx_clk`=1. Once it has arrived, `rd_dat` holds the 18 data bits, `rd_drive` is 1 and `lnk_oe` is 1. `rd_drive` clears on the next rising edge of the active strobe.
- R5: `rd_err` is set at the end of a read when any of the 6 returned control bits is 1, and is cleared at the end of a read when all of them are 0.
- R6: With `par_mode`=0 and `host_sel`=0, each rising edge of `host_ctl[5]` sends a 9-bit frame: start bit 1, `host_sel`, `host_rw`, the synchronized level of `strb0` in the bit-5 position, then `host_ctl[4:0]`. Falling edges send nothing.
- R7: With `par_mode`=0 and `host_sel`=1, `strb1` keeps the full parallel write behaviour of R2.
- R8: When no frame is in flight, `lnk_clk` and `lnk_dat` are 0 and `lnk_oe` is 1 (outside a read turnaround).
- R9: An edge that would start a transaction while a frame is being sent or received gives a one-cycle pulse on `overrun`. It is otherwise ignored, so the frame in flight and its length are unchanged.
- R10: After reset the link is idle, and `rd_drive`, `rd_err` and `overrun` are 0.
- R11: A falling edge with `host_rw`=0 starts nothing, and neither does a rising edge with `host_rw`=1 when no read is being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_mode | input | 1 | 1 = parallel mode, 0 = SPI pass-through on channel 0 |
| host_sel | input | 1 | Strobe select, sent in every frame |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_ctl | input | 6 | Control bits; bit 5 is the SPI clock in SPI mode |
| host_dat | input | 18 | Write data |
| strb0 | input | 1 | Strobe for channel 0; chip select in SPI mode |
| strb1 | input | 1 | Strobe for channel 1 |
| rd_dat | output | 18 | Data returned by the last read |
| rd_drive | output | 1 | Host data bus should be driven with `rd_dat` |
| rd_err | output | 1 | Control bits of the last returned frame were not zero |
| overrun | output | 1 | One-cycle pulse: a start edge arrived while busy |
| lnk_clk | output | 1 | Link bit qualifier; one frame bit per high cycle |
| lnk_dat | output | 1 | Link data out |
| lnk_oe | output | 1 | Master owns the link (0 during read turnaround) |
| lnk_rx_clk | input | 1 | Return bit qualifier from the far end |
| lnk_rx_dat | input | 1 | Return data from the far end |

## Verification
The bench goes after the edge-polarity rules. A design that captured writes on the falling edge, or reads on the rising edge, would send a frame for the ignored edges or send a write-sized frame for a read. In SPI mode it checks that the chip-select level replaces bit 5 and that no data bits follow; a design that forgot the swap would send the clock level instead. It sends a second strobe while a frame is still in flight and expects exactly one overrun pulse and an unchanged 27-bit frame. A design that restarted would lengthen or corrupt the frame. It also returns a frame with nonzero control bits and then a clean one, to catch an error flag that sticks or never rises.

// File: rtl/dsl_pkg.sv
// Shared types for the master link serializer.
package dsl_pkg;
    // Transaction engine states: idle, shifting out, receiving, holding read data.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2,
        ST_HOLD = 2'd3
    } link_state_t;
endpackage

// File: rtl/dsl_strobe_front.sv
// Strobe front end: synchronizes the three possible strobe sources into clk,
// selects the active one and reports its rising and falling edges.
// Assumes SYNC_STAGES >= 2 and that the mode/select inputs change only while
// every candidate strobe sits at its idle high level.
module dsl_strobe_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb0_i,
    input  logic strb1_i,
    input  logic sclk_i,
    input  logic par_mode_i,
    input  logic sel_i,
    output logic rise_o,
    output logic fall_o,
    output logic cs_o
);
    localparam int NSRC = 3;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] synced;
    logic            act;
    logic            act_q;

    assign raw = {sclk_i, strb1_i, strb0_i};

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            // Shift the raw strobe through the synchronizer chain; idle level is high.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Pick the active strobe from mode and select.
    always_comb begin
        if (sel_i)           act = synced[1];
        else if (par_mode_i) act = synced[0];
        else                 act = synced[2];
    end

    // Remember the previous active level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b1;
        else        act_q <= act;
    end

    assign rise_o = act & ~act_q;
    assign fall_o = ~act & act_q;
    assign cs_o   = synced[0];
endmodule

// File: rtl/dsl_frame_tx.sv
// Frame shifter: loads a left-aligned frame and a bit count, then sends one
// bit per cycle MSB first with lnk_clk_o high. Outputs are low when empty.
// Assumes load_i is only raised while no frame is in flight.
module dsl_frame_tx #(
    parameter int SH_W = 27
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [SH_W-1:0]            word_i,
    input  logic [$clog2(SH_W+1)-1:0]  len_i,
    output logic                       lnk_clk_o,
    output logic                       lnk_dat_o,
    output logic                       last_o
);
    localparam int LEN_W = $clog2(SH_W + 1);

    logic [SH_W-1:0]  sh;
    logic [LEN_W-1:0] cnt;

    // Load a new frame or advance the one in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load_i) begin
            sh  <= word_i;
            cnt <= len_i;
        end else if (cnt != '0) begin
            sh  <= sh << 1;
            cnt <= cnt - 1'b1;
        end
    end

    assign lnk_clk_o = (cnt != '0);
    assign lnk_dat_o = (cnt != '0) && sh[SH_W-1];
    assign last_o    = (cnt == LEN_W'(1));
endmodule

// File: rtl/dsl_frame_rx.sv
// Return-frame receiver: while enabled, waits for a start bit of 1 and then
// collects WORD_W bits MSB first, one per cycle with rx_clk_i high.
// done_o is a one-cycle strobe together with the complete word.
module dsl_frame_rx #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              rx_clk_i,
    input  logic              rx_dat_i,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic              started;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sh;
    logic              last_bit;

    assign last_bit = started && (cnt == CNT_W'(WORD_W - 1));

    // Hunt for the start bit, then shift in the payload bits.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            started <= 1'b0;
            cnt     <= '0;
            sh      <= '0;
        end else if (rx_clk_i) begin
            if (!started) begin
                started <= rx_dat_i;
                cnt     <= '0;
            end else begin
                sh  <= {sh[WORD_W-2:0], rx_dat_i};
                cnt <= cnt + 1'b1;
                if (last_bit) started <= 1'b0;
            end
        end
    end

    assign done_o = en_i && rx_clk_i && last_bit;
    assign word_o = {sh[WORD_W-2:0], rx_dat_i};
endmodule

// File: rtl/dsl_master.sv
// Master link serializer top. Turns host strobe edges into link frames:
// full write frames, short control frames for reads and SPI pass-through,
// and for reads a turnaround that receives and holds the returned data.
// Assumes host inputs stay stable from the strobe edge until the frame is
// loaded (synchronizer delay plus one cycle).
module dsl_master #(
    parameter int DATA_W      = 18,
    parameter int CTL_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_mode,
    input  logic              host_sel,
    input  logic              host_rw,
    input  logic [CTL_W-1:0]  host_ctl,
    input  logic [DATA_W-1:0] host_dat,
    input  logic              strb0,
    input  logic              strb1,
    output logic [DATA_W-1:0] rd_dat,
    output logic              rd_drive,
    output logic              rd_err,
    output logic              overrun,
    output logic              lnk_clk,
    output logic              lnk_dat,
    output logic              lnk_oe,
    input  logic              lnk_rx_clk,
    input  logic              lnk_rx_dat
);
    import dsl_pkg::*;

    localparam int HDR_W = CTL_W + 2;
    localparam int SH_W  = 1 + HDR_W + DATA_W;
    localparam int LEN_W = $clog2(SH_W + 1);
    localparam int RX_W  = DATA_W + CTL_W;

    link_state_t       state;
    logic              is_rd;
    logic              rise, fall, cs;
    logic              spi_ch0, wr_trig, rd_trig, trig, ctl_only, load;
    logic [CTL_W-1:0]  ctl_eff;
    logic [SH_W-1:0]   tx_word;
    logic [LEN_W-1:0]  tx_len;
    logic              tx_last;
    logic              rx_done;
    logic [RX_W-1:0]   rx_word;

    dsl_strobe_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .strb0_i    (strb0),
        .strb1_i    (strb1),
        .sclk_i     (host_ctl[CTL_W-1]),
        .par_mode_i (par_mode),
        .sel_i      (host_sel),
        .rise_o     (rise),
        .fall_o     (fall),
        .cs_o       (cs)
    );

    // Classify the detected edge into write/read start and build the frame.
    always_comb begin
        spi_ch0  = !par_mode && !host_sel;
        wr_trig  = rise && (spi_ch0 || !host_rw);
        rd_trig  = fall && !spi_ch0 && host_rw;
        trig     = wr_trig || rd_trig;
        ctl_only = spi_ch0 || rd_trig;
        load     = trig && (state == ST_IDLE);
        ctl_eff  = spi_ch0 ? {cs, host_ctl[CTL_W-2:0]} : host_ctl;
        tx_word  = {1'b1, host_sel, host_rw, ctl_eff,
                    (ctl_only ? {DATA_W{1'b0}} : host_dat)};
        tx_len   = ctl_only ? LEN_W'(HDR_W + 1) : LEN_W'(SH_W);
    end

    dsl_frame_tx #(.SH_W(SH_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .word_i    (tx_word),
        .len_i     (tx_len),
        .lnk_clk_o (lnk_clk),
        .lnk_dat_o (lnk_dat),
        .last_o    (tx_last)
    );

    dsl_frame_rx #(.WORD_W(RX_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (state == ST_RECV),
        .rx_clk_i (lnk_rx_clk),
        .rx_dat_i (lnk_rx_dat),
        .done_o   (rx_done),
        .word_o   (rx_word)
    );

    // Transaction sequencing: send, turn around for reads, hold returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            is_rd    <= 1'b0;
            rd_dat   <= '0;
            rd_drive <= 1'b0;
            rd_err   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (load) begin
                    state <= ST_SEND;
                    is_rd <= rd_trig;
                end
                ST_SEND: if (tx_last) state <= is_rd ? ST_RECV : ST_IDLE;
                ST_RECV: if (rx_done) begin
                    rd_dat   <= rx_word[RX_W-1 -: DATA_W];
                    rd_err   <= |rx_word[CTL_W-1:0];
                    rd_drive <= 1'b1;
                    state    <= ST_HOLD;
                end
                ST_HOLD: if (rise) begin
                    rd_drive <= 1'b0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Flag start edges that arrive while a frame is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= trig && (state == ST_SEND || state == ST_RECV);
    end

    assign lnk_oe = (state != ST_RECV);
endmodule

// File: rtl/dsl_master_chk.sv
// Property checker for dsl_master, attached by bind below.
module dsl_master_chk (
    input logic                clk,
    input logic                rst_n,
    input dsl_pkg::link_state_t state,
    input logic                lnk_clk,
    input logic                lnk_dat,
    input logic                lnk_oe,
    input logic                rd_drive,
    input logic                overrun
);
    import dsl_pkg::*;

    AST_START_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_clk) |-> lnk_dat); // R2

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!lnk_clk && !lnk_dat)); // R8

    AST_TURN_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lnk_oe) |-> $past(lnk_clk)); // R4

    AST_NO_SEND_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_oe |-> !lnk_clk); // R4

    AST_DRIVE_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> lnk_oe); // R4

    AST_OVERRUN_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(state) == ST_SEND || $past(state) == ST_RECV)); // R9
endmodule

bind dsl_master dsl_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .lnk_clk  (lnk_clk),
    .lnk_dat  (lnk_dat),
    .lnk_oe   (lnk_oe),
    .rd_drive (rd_drive),
    .overrun  (overrun)
);

// File: tb/sim_dsl_master.sv
// Bench for dsl_master: vector table walk, then directed corner cases.
module sim_dsl_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        par_mode = 1'b1, host_sel = 1'b0, host_rw = 1'b0;
    logic [5:0]  host_ctl = 6'h20;
    logic [17:0] host_dat = '0;
    logic        strb0 = 1'b1, strb1 = 1'b1;
    logic [17:0] rd_dat;
    logic        rd_drive, rd_err, overrun, lnk_clk, lnk_dat, lnk_oe;
    logic        lnk_rx_clk = 1'b0, lnk_rx_dat = 1'b0;

    int tests = 0, fails = 0;
    logic [63:0] cap = '0;
    int bit_total = 0, ov_total = 0;

    always #10 clk = ~clk;

    dsl_master u0 (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .host_sel(host_sel),
        .host_rw(host_rw), .host_ctl(host_ctl), .host_dat(host_dat),
        .strb0(strb0), .strb1(strb1), .rd_dat(rd_dat), .rd_drive(rd_drive),
        .rd_err(rd_err), .overrun(overrun), .lnk_clk(lnk_clk), .lnk_dat(lnk_dat),
        .lnk_oe(lnk_oe), .lnk_rx_clk(lnk_rx_clk), .lnk_rx_dat(lnk_rx_dat)
    );

    // Link monitor: collect sent bits and overrun pulses away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && lnk_clk) begin
            cap       <= {cap[62:0], lnk_dat};
            bit_total <= bit_total + 1;
        end
        if (rst_n && overrun) ov_total <= ov_total + 1;
    end

    // Vector: par[51] sel[50] rw[49] cs[48] ctl[47:42] dat[41:24] rctl[23:18] rdat[17:0]
    localparam logic [51:0] VEC [8] = '{
        {1'b1, 1'b0, 1'b0, 1'b1, 6'h15, 18'h2A5A5, 6'h00, 18'h00000},
        {1'b1, 1'b1, 1'b0, 1'b1, 6'h3C, 18'h3FFFF, 6'h00, 18'h00000},
        {1'b1, 1'b0, 1'b1, 1'b1, 6'h0A, 18'h1234F, 6'h00, 18'h2BEEF},
        {1'b1, 1'b1, 1'b1, 1'b1, 6'h21, 18'h3F00F, 6'h04, 18'h00F0F},
        {1'b0, 1'b0, 1'b0, 1'b0, 6'h2B, 18'h3AAAA, 6'h00, 18'h00000},
        {1'b0, 1'b0, 1'b0, 1'b1, 6'h16, 18'h15555, 6'h00, 18'h00000},
        {1'b0, 1'b1, 1'b0, 1'b1, 6'h07, 18'h15555, 6'h00, 18'h00000},
        {1'b1, 1'b0, 1'b1, 1'b1, 6'h33, 18'h00001, 6'h00, 18'h3FFFF}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_strobe(input bit which, input bit lvl);
        if (which) strb1 = lvl;
        else       strb0 = lvl;
    endtask

    task automatic check_frame(input string tag, input int start, input int len, input logic [63:0] exp);
        logic [63:0] mask;
        mask = (64'd1 << len) - 64'd1;
        chk(bit_total - start == len, {tag, " length"}, 64'(bit_total - start), 64'(len));
        chk((cap & mask) == exp, {tag, " bits"}, cap & mask, exp);
    endtask

    // Far-end model: once the link is released, send start bit, data, control.
    task automatic respond(input logic [17:0] d, input logic [5:0] c);
        logic [24:0] word;
        int n;
        n = 0;
        while (lnk_oe && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(!lnk_oe, "R4 link released after read frame", 64'(lnk_oe), 64'd0);
        waitn(3);
        word = {1'b1, d, c};
        for (int k = 24; k >= 0; k--) begin
            lnk_rx_clk = 1'b1;
            lnk_rx_dat = word[k];
            @(negedge clk);
        end
        lnk_rx_clk = 1'b0;
        lnk_rx_dat = 1'b0;
    endtask

    task automatic set_mode(input bit p, input bit s);
        host_ctl[5] = 1'b1;
        waitn(4);
        par_mode = p;
        host_sel = s;
        waitn(5);
    endtask

    task automatic run_vec(input logic [51:0] v);
        bit p, s, w, c;
        logic [5:0]  ct, rc;
        logic [17:0] d, rd;
        int start;
        {p, s, w, c, ct, d, rc, rd} = v;
        set_mode(p, s);
        start = bit_total;
        host_dat = d;
        if (!p && !s) begin
            strb0 = c;
            host_rw = w;
            host_ctl[4:0] = ct[4:0];
            waitn(4);
            host_ctl[5] = 1'b0;
            waitn(4);
            chk(bit_total == start, "R6 falling SPI clock sends nothing", 64'(bit_total - start), 64'd0);
            host_ctl[5] = 1'b1;
            waitn(45);
            check_frame("R6 SPI control frame", start, 9, 64'({1'b1, s, w, c, ct[4:0]}));
            strb0 = 1'b1;
            waitn(4);
        end else if (!w) begin
            host_ctl = ct;
            host_rw = 1'b0;
            waitn(3);
            drive_strobe(s, 1'b0);
            waitn(4);
            drive_strobe(s, 1'b1);
            waitn(45);
            check_frame(p ? "R1 R2 write frame" : "R7 strobe1 write in SPI mode",
                        start, 27, 64'({1'b1, s, 1'b0, ct, d}));
        end else begin
            host_ctl = ct;
            host_rw = 1'b1;
            waitn(3);
            drive_strobe(s, 1'b0);
            respond(rd, rc);
            waitn(3);
            check_frame("R1 R3 read control frame", start, 9, 64'({1'b1, s, 1'b1, ct}));
            chk(rd_drive === 1'b1, "R4 rd_drive after return", 64'(rd_drive), 64'd1);
            chk(rd_dat === rd, "R4 returned data", 64'(rd_dat), 64'(rd));
            chk(rd_err === (rc != 6'd0), "R5 return control check", 64'(rd_err), 64'(rc != 6'd0));
            drive_strobe(s, 1'b1);
            waitn(6);
            chk(rd_drive === 1'b0, "R4 rd_drive cleared by rising strobe", 64'(rd_drive), 64'd0);
            host_rw = 1'b0;
        end
        chk(lnk_clk === 1'b0 && lnk_dat === 1'b0 && lnk_oe === 1'b1, "R8 idle link",
            64'({lnk_clk, lnk_dat, lnk_oe}), 64'b001);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog (all requirements): act=expired exp=finished");
        summary();
        $finish;
    end

    initial begin
        int start, ov0;
        waitn(5);
        // R10 / R8: reset state
        chk(lnk_clk === 1'b0, "R10 lnk_clk in reset", 64'(lnk_clk), 64'd0);
        chk(lnk_dat === 1'b0, "R10 lnk_dat in reset", 64'(lnk_dat), 64'd0);
        chk(lnk_oe === 1'b1, "R10 lnk_oe in reset", 64'(lnk_oe), 64'd1);
        chk(rd_drive === 1'b0 && rd_err === 1'b0 && overrun === 1'b0, "R10 flags in reset",
            64'({rd_drive, rd_err, overrun}), 64'd0);
        rst_n = 1'b1;
        waitn(10);
        chk(bit_total == 0, "R8 no frame after reset release", 64'(bit_total), 64'd0);

        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // R9: second write edge while the first frame is in flight
        set_mode(1'b1, 1'b0);
        host_ctl = 6'h2E;
        host_dat = 18'h0F0F0;
        host_rw = 1'b0;
        waitn(3);
        start = bit_total;
        ov0 = ov_total;
        strb0 = 1'b0; waitn(4); strb0 = 1'b1;
        waitn(10);
        host_dat = 18'h3FFFF;
        strb0 = 1'b0; waitn(4); strb0 = 1'b1;
        waitn(60);
        chk(ov_total - ov0 == 1, "R9 one overrun pulse", 64'(ov_total - ov0), 64'd1);
        check_frame("R9 frame unchanged by overrun", start, 27, 64'({1'b1, 1'b0, 1'b0, 6'h2E, 18'h0F0F0}));

        // R11: falling edge of a write and rising edge of a read start nothing
        start = bit_total;
        strb0 = 1'b0;
        waitn(30);
        chk(bit_total == start, "R11 falling edge with write", 64'(bit_total - start), 64'd0);
        host_rw = 1'b1;
        waitn(4);
        strb0 = 1'b1;
        waitn(30);
        chk(bit_total == start && rd_drive === 1'b0, "R11 rising edge with read flag",
            64'(bit_total - start), 64'd0);
        host_rw = 1'b0;
        waitn(4);
        // R1: unselected strobe starts nothing
        strb1 = 1'b0; waitn(4); strb1 = 1'b1;
        waitn(30);
        chk(bit_total == start, "R1 unselected strobe ignored", 64'(bit_total - start), 64'd0);

        summary();
        $finish;
    end
endmodule